// File: doc/BRIEF.md
# Distributed TDM memory arbitration tree

This block joins a set of processor-side network interfaces to a single memory controller port. Commands travel through a pipelined binary merge tree to the memory side. Read data comes back through a matching pipelined fan-out tree. Time on the memory port is divided into a fixed round of slots, one slot per core and of equal length. Each slot carries one command flit. For a write, the command flit is followed by a four-word cache-line burst.

No central arbiter exists anywhere in the block. Every network interface keeps its own copy of the slot counter. All copies are cleared by the same reset and are advanced by the fixed downstream latency. As a result, an interface injects a command only in the cycle that makes the command reach the memory port at the start of its core's slot. Merge nodes only OR their two children and register the result, so they never stall or buffer a flit.

A core that has a request holds it steady until its interface pulses `core_taken`. For a write, the core also keeps the write words steady for the four cycles that follow the pulse. The controller needs no request queue. It serves each command in the slot in which the command arrives, and it returns read words a fixed number of cycles later.

Top module: `tdm_mem_tree`

## Requirements
- R1: Commands from the cores reach the memory port in the fixed cyclic order of core index, one slot of SLOT_LEN cycles each, with a round of N_CORES*SLOT_LEN cycles.
- R2: A command flit appears on the memory port (`mem_valid`=1, `mem_cmd`=1) exactly log2(N_CORES)*STAGE_DEPTH cycles after the cycle in which its core saw `core_taken`.
- R3: `core_taken` rises for a core only in the first cycle of that core's injection window and only while its request is valid, and it is high for at most one core in any cycle.
- R4: For a write, the four data flits (`mem_valid`=1, `mem_cmd`=0) follow the command on the next four consecutive cycles. Word j is taken from bits [(i*4+j)*DATA_W +: DATA_W] of `core_req_wdata` for core i.
- R5: For a read, only the command flit is sent, and `mem_valid` stays low for the rest of the slot.
- R6: When no core has a request, `mem_valid` and `core_taken` stay low, and the slots go unused.
- R7: A response word presented on `mem_rvalid`/`mem_rdata` in cycle m appears log2(N_CORES)*STAGE_DEPTH cycles later on `core_rvalid`/`core_rdata` of exactly one core. That core is the owner of the memory slot that held cycle m minus RESP_LAT. All other cores see `core_rvalid` low.
- R8: While reset is asserted, `core_taken`, `mem_valid` and `core_rvalid` are all low, whatever the inputs are.
- R9: No merge node ever receives valid flits from both of its children in the same cycle.
- R10: A core that keeps its request valid is served once per round, with `core_taken` pulses exactly N_CORES*SLOT_LEN cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_req_valid | input | N_CORES | Per-core request pending |
| core_req_wr | input | N_CORES | Per-core request is a write |
| core_req_addr | input | N_CORES*ADDR_W | Per-core request address |
| core_req_wdata | input | N_CORES*4*DATA_W | Per-core write burst, four words |
| core_taken | output | N_CORES | Pulse: this core's command was injected this cycle |
| core_rvalid | output | N_CORES | Read word delivered to this core |
| core_rdata | output | N_CORES*DATA_W | Read word per core |
| mem_valid | output | 1 | Flit valid at memory port |
| mem_cmd | output | 1 | Flit is a command (else a write data word) |
| mem_wr | output | 1 | Command is a write |
| mem_addr | output | ADDR_W | Command address |
| mem_wdata | output | DATA_W | Write data word |
| mem_rvalid | input | 1 | Read word valid from controller |
| mem_rdata | input | DATA_W | Read word from controller |

## Verification
The assertions check on every cycle the properties that hold at each clock edge. These are: at most one injection pulse and at most one response delivery per cycle, no merge node ever seeing two valid children, every command surfacing at the memory port exactly the downstream latency after an injection, and every delivered response word matching a controller word one upstream latency earlier. Other properties need a whole transaction or a whole round to show, so only the directed scenarios can check them. These are the cyclic slot order and spacing across cores, the order and content of write words, the quiet tail of a read slot, the choice of the correct core for each response, and the one-round spacing of repeated service.

// File: rtl/tdm_tree_pkg.sv
package tdm_tree_pkg;
  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 32;
  localparam int BURST_LEN = 4;

  // flit travelling toward memory; an idle flit is all zero so merging is an OR
  typedef struct packed {
    logic              valid;
    logic              cmd;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } flit_t;

  // word travelling back toward the cores
  typedef struct packed {
    logic              valid;
    logic [DATA_W-1:0] data;
  } rsp_t;

  localparam int FLIT_W = $bits(flit_t);
  localparam int RSP_W  = $bits(rsp_t);
endpackage

// File: rtl/tdm_pipe.sv
module tdm_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < DEPTH; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/tdm_merge_node.sv
module tdm_merge_node
  import tdm_tree_pkg::*;
#(
  parameter int STAGE_DEPTH = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  flit_t left_i,
  input  flit_t right_i,
  output flit_t merged_o
);
  flit_t joined;

  // the schedule guarantees at most one child is non-idle
  assign joined = left_i | right_i;

  tdm_pipe #(.W(FLIT_W), .DEPTH(STAGE_DEPTH)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (joined),
    .q     (merged_o)
  );
endmodule

// File: rtl/tdm_slot_ni.sv
module tdm_slot_ni
  import tdm_tree_pkg::*;
#(
  parameter int N_CORES  = 4,
  parameter int SLOT_LEN = 5,
  parameter int CORE_ID  = 0,
  parameter int CNT_RST  = 0,
  parameter int RSP_OFF  = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_wr,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [BURST_LEN*DATA_W-1:0] req_wdata,
  output logic                        taken,
  output flit_t                       flit_o,
  input  rsp_t                        rsp_i,
  output logic                        rvalid,
  output logic [DATA_W-1:0]           rdata
);
  localparam int PERIOD = N_CORES * SLOT_LEN;
  localparam int CW     = $clog2(PERIOD);
  localparam int WIN_LO = CORE_ID * SLOT_LEN;
  localparam int WIN_HI = WIN_LO + SLOT_LEN;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          live_q;
  logic          burst_q, burst_d;
  int            cnt_i, beat_i, rph_i;
  logic          in_win, own_rsp;

  // next-state: local replica of the round counter
  always_comb begin
    if (cnt_q == CW'(PERIOD - 1)) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  assign cnt_i  = int'(cnt_q);
  assign in_win = (cnt_i >= WIN_LO) && (cnt_i < WIN_HI);
  assign beat_i = cnt_i - WIN_LO;

  // injection side
  always_comb begin
    flit_o  = '0;
    taken   = 1'b0;
    burst_d = burst_q;
    if (live_q && in_win) begin
      if (beat_i == 0) begin
        burst_d = req_valid && req_wr;
        if (req_valid) begin
          taken        = 1'b1;
          flit_o.valid = 1'b1;
          flit_o.cmd   = 1'b1;
          flit_o.wr    = req_wr;
          flit_o.addr  = req_addr;
        end
      end else if (burst_q && beat_i <= BURST_LEN) begin
        flit_o.valid = 1'b1;
        flit_o.data  = req_wdata[(beat_i-1)*DATA_W +: DATA_W];
      end
    end
  end

  // response side: same counter seen through the full round-trip latency
  assign rph_i   = (cnt_i >= RSP_OFF) ? (cnt_i - RSP_OFF) : (cnt_i + PERIOD - RSP_OFF);
  assign own_rsp = (rph_i >= WIN_LO) && (rph_i < WIN_HI);
  assign rvalid  = own_rsp && rsp_i.valid;
  assign rdata   = rvalid ? rsp_i.data : '0;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CW'(CNT_RST);
      live_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (live_q) begin
        cnt_q   <= cnt_d;
        burst_q <= burst_d;
      end
    end
  end
endmodule

// File: rtl/tdm_mem_tree.sv
module tdm_mem_tree
  import tdm_tree_pkg::*;
#(
  parameter int N_CORES     = 4,
  parameter int SLOT_LEN    = 5,
  parameter int STAGE_DEPTH = 1,
  parameter int RESP_LAT    = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N_CORES-1:0]                  core_req_valid,
  input  logic [N_CORES-1:0]                  core_req_wr,
  input  logic [N_CORES*ADDR_W-1:0]           core_req_addr,
  input  logic [N_CORES*BURST_LEN*DATA_W-1:0] core_req_wdata,
  output logic [N_CORES-1:0]                  core_taken,
  output logic [N_CORES-1:0]                  core_rvalid,
  output logic [N_CORES*DATA_W-1:0]           core_rdata,
  output logic                                mem_valid,
  output logic                                mem_cmd,
  output logic                                mem_wr,
  output logic [ADDR_W-1:0]                   mem_addr,
  output logic [DATA_W-1:0]                   mem_wdata,
  input  logic                                mem_rvalid,
  input  logic [DATA_W-1:0]                   mem_rdata
);
  localparam int LEVELS  = $clog2(N_CORES);
  localparam int LDOWN   = LEVELS * STAGE_DEPTH;
  localparam int LUP     = LEVELS * STAGE_DEPTH;
  localparam int PERIOD  = N_CORES * SLOT_LEN;
  localparam int CNT_RST = LDOWN % PERIOD;
  localparam int RSP_OFF = (LDOWN + RESP_LAT + LUP) % PERIOD;
  localparam int NODES   = 2 * N_CORES;

  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  // heap-indexed trees: node 1 is the root, leaves sit at N_CORES + i
  flit_t             cmd_node [1:NODES-1];
  rsp_t              rsp_node [1:NODES-1];
  logic [NODES-1:1]  node_valid;

  assign rsp_node[1] = {mem_rvalid, mem_rdata};

  for (genvar i = 0; i < N_CORES; i++) begin : g_ni
    tdm_slot_ni #(
      .N_CORES  (N_CORES),
      .SLOT_LEN (SLOT_LEN),
      .CORE_ID  (i),
      .CNT_RST  (CNT_RST),
      .RSP_OFF  (RSP_OFF)
    ) u_ni (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .req_valid (core_req_valid[i]),
      .req_wr    (core_req_wr[i]),
      .req_addr  (core_req_addr[i*ADDR_W +: ADDR_W]),
      .req_wdata (core_req_wdata[i*BURST_LEN*DATA_W +: BURST_LEN*DATA_W]),
      .taken     (core_taken[i]),
      .flit_o    (cmd_node[N_CORES+i]),
      .rsp_i     (rsp_node[N_CORES+i]),
      .rvalid    (core_rvalid[i]),
      .rdata     (core_rdata[i*DATA_W +: DATA_W])
    );
  end

  for (genvar k = 1; k < N_CORES; k++) begin : g_merge
    tdm_merge_node #(.STAGE_DEPTH(STAGE_DEPTH)) u_node (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .left_i   (cmd_node[2*k]),
      .right_i  (cmd_node[2*k+1]),
      .merged_o (cmd_node[k])
    );
  end

  for (genvar k = 2; k < NODES; k++) begin : g_rsp
    tdm_pipe #(.W(RSP_W), .DEPTH(STAGE_DEPTH)) u_stage (
      .clk   (clk),
      .rst_n (rst_q_n),
      .d     (rsp_node[k/2]),
      .q     (rsp_node[k])
    );
  end

  for (genvar k = 1; k < NODES; k++) begin : g_nv
    assign node_valid[k] = cmd_node[k].valid;
  end

  assign mem_valid = cmd_node[1].valid;
  assign mem_cmd   = cmd_node[1].cmd;
  assign mem_wr    = cmd_node[1].wr;
  assign mem_addr  = cmd_node[1].addr;
  assign mem_wdata = cmd_node[1].data;
endmodule

// File: rtl/tdm_mem_tree_chk.sv
module tdm_mem_tree_chk #(
  parameter int N_CORES = 4,
  parameter int LDOWN   = 2,
  parameter int LUP     = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_CORES-1:0]     core_taken,
  input logic [N_CORES-1:0]     core_rvalid,
  input logic                   mem_valid,
  input logic                   mem_cmd,
  input logic                   mem_rvalid,
  input logic [2*N_CORES-1:1]   node_valid
);
  logic [LDOWN-1:0] inj_hist_q;
  logic [LUP-1:0]   rsp_hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_hist_q <= '0;
      rsp_hist_q <= '0;
    end else begin
      inj_hist_q <= (inj_hist_q << 1) | LDOWN'(|core_taken);
      rsp_hist_q <= (rsp_hist_q << 1) | LUP'(mem_rvalid);
    end
  end

  // R3
  single_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_taken));

  // R2
  cmd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_cmd) == inj_hist_q[LDOWN-1]);

  // R7
  single_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_rvalid));

  // R7
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_rvalid) == rsp_hist_q[LUP-1]);

  for (genvar k = 1; k < N_CORES; k++) begin : g_clash
    // R9
    merge_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(node_valid[2*k] && node_valid[2*k+1]));
  end
endmodule

bind tdm_mem_tree tdm_mem_tree_chk #(
  .N_CORES (N_CORES),
  .LDOWN   (LDOWN),
  .LUP     (LUP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .core_taken  (core_taken),
  .core_rvalid (core_rvalid),
  .mem_valid   (mem_valid),
  .mem_cmd     (mem_cmd),
  .mem_rvalid  (mem_rvalid),
  .node_valid  (node_valid)
);

// File: tb/sim_tdm_mem_tree.sv
module sim_tdm_mem_tree;
  import tdm_tree_pkg::*;

  localparam int N     = 4;
  localparam int L     = 5;
  localparam int SD    = 1;
  localparam int RL    = 3;
  localparam int LV    = 2;
  localparam int LDOWN = LV * SD;
  localparam int LUP   = LV * SD;
  localparam int P     = N * L;
  localparam int BL    = BURST_LEN;
  localparam int DW    = DATA_W;
  localparam int AW    = ADDR_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_n;
  logic [N-1:0]           req_valid, req_wr;
  logic [N*AW-1:0]        req_addr;
  logic [N*BL*DW-1:0]     req_wdata;
  logic [N-1:0]           core_taken, core_rvalid;
  logic [N*DW-1:0]        core_rdata;
  logic                   mem_valid, mem_cmd, mem_wr;
  logic [AW-1:0]          mem_addr;
  logic [DW-1:0]          mem_wdata;
  logic                   mem_rvalid;
  logic [DW-1:0]          mem_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  tdm_mem_tree #(
    .N_CORES(N), .SLOT_LEN(L), .STAGE_DEPTH(SD), .RESP_LAT(RL)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(req_valid), .core_req_wr(req_wr),
    .core_req_addr(req_addr), .core_req_wdata(req_wdata),
    .core_taken(core_taken), .core_rvalid(core_rvalid), .core_rdata(core_rdata),
    .mem_valid(mem_valid), .mem_cmd(mem_cmd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_req(input int i, input bit v, input bit wr,
                         input logic [AW-1:0] addr, input logic [DW-1:0] base);
    req_valid[i]          = v;
    req_wr[i]             = wr;
    req_addr[i*AW +: AW]  = addr;
    for (int j = 0; j < BL; j++) req_wdata[(i*BL+j)*DW +: DW] = base + DW'(j);
  endtask

  // one transaction from core i, with the bench acting as controller
  task automatic do_txn(input int i, input bit wr, input logic [AW-1:0] addr,
                        input logic [DW-1:0] base);
    bit            found = 1'b0;
    int            j, jr;
    bit            ev, er;
    logic [N-1:0]  oh   = N'(1) << i;
    logic [DW-1:0] rtag = base ^ 32'h5A5A_0000;
    set_req(i, 1'b1, wr, addr, base);
    for (int w = 0; w < P + 2 && !found; w++) begin
      @(negedge clk);
      if (core_taken[i]) found = 1'b1;
    end
    chk("R3", "injection pulse seen", 64'(found), 64'd1);
    if (!found) begin
      req_valid[i] = 1'b0;
      return;
    end
    chk("R3", "only owner pulses", 64'(core_taken), 64'(oh));
    for (int k = 1; k <= LDOWN + RL + BL + LUP + 1; k++) begin
      @(posedge clk); #1;
      if (k == 1) req_valid[i] = 1'b0;
      j          = k - (LDOWN + RL);
      mem_rvalid = !wr && j >= 0 && j < BL;
      mem_rdata  = (j >= 0 && j < BL) ? rtag + DW'(j) : '0;
      @(negedge clk);
      ev = (k == LDOWN) || (wr && k > LDOWN && k <= LDOWN + BL);
      chk(wr ? "R4" : "R5", $sformatf("mem_valid k=%0d", k), 64'(mem_valid), 64'(ev));
      if (ev && k == LDOWN) begin
        chk("R2", "command flit at latency", 64'(mem_cmd), 64'd1);
        chk("R2", "command kind", 64'(mem_wr), 64'(wr));
        chk("R2", "command address", 64'(mem_addr), 64'(addr));
      end else if (ev) begin
        chk("R4", "data flit kind", 64'(mem_cmd), 64'd0);
        chk("R4", $sformatf("write word %0d", k - LDOWN - 1), 64'(mem_wdata),
            64'(base + DW'(k - LDOWN - 1)));
      end
      jr = k - (LDOWN + RL + LUP);
      er = !wr && jr >= 0 && jr < BL;
      chk("R7", $sformatf("rvalid routing k=%0d", k), 64'(core_rvalid), er ? 64'(oh) : 64'd0);
      if (er) chk("R7", "read word", 64'(core_rdata[i*DW +: DW]), 64'(rtag + DW'(jr)));
      chk("R3", "no pulse after request dropped", 64'(core_taken), 64'd0);
    end
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
  endtask

  task automatic t_reset();
    rst_n      = 1'b0;
    req_valid  = '1;
    req_wr     = '0;
    req_addr   = '0;
    req_wdata  = '0;
    mem_rvalid = 1'b1;
    mem_rdata  = 32'hDEAD_BEEF;
    repeat (3) begin
      @(negedge clk);
      chk("R8", "taken in reset", 64'(core_taken), 64'd0);
      chk("R8", "mem_valid in reset", 64'(mem_valid), 64'd0);
      chk("R8", "rvalid in reset", 64'(core_rvalid), 64'd0);
    end
    req_valid  = '0;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_idle();
    bit any_mem = 1'b0;
    bit any_tk  = 1'b0;
    for (int c = 0; c < 2 * P; c++) begin
      @(negedge clk);
      if (mem_valid) any_mem = 1'b1;
      if (|core_taken) any_tk = 1'b1;
    end
    chk("R6", "idle round mem_valid", 64'(any_mem), 64'd0);
    chk("R6", "idle round taken", 64'(any_tk), 64'd0);
  endtask

  task automatic t_all_order();
    int tk[N];
    int mc[N];
    int idx;
    for (int i = 0; i < N; i++) begin
      tk[i] = -1;
      mc[i] = -1;
      set_req(i, 1'b1, 1'b0, AW'(32'h100 + i), '0);
    end
    for (int c = 0; c < P + LDOWN + 2; c++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++)
        if (core_taken[i] && tk[i] < 0) tk[i] = c;
      if (mem_valid && mem_cmd) begin
        idx = int'(mem_addr) - 32'h100;
        if (idx >= 0 && idx < N && mc[idx] < 0) mc[idx] = c;
      end
      @(posedge clk); #1;
      for (int i = 0; i < N; i++)
        if (tk[i] >= 0) req_valid[i] = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      chk("R2", $sformatf("core %0d cmd latency", i), 64'(mc[i] - tk[i]), 64'(LDOWN));
      chk("R1", $sformatf("slot after core %0d", i),
          64'((tk[(i+1)%N] - tk[i] + P) % P), 64'(L));
    end
  endtask

  task automatic t_back_to_back();
    int t0 = -1;
    int t1 = -1;
    set_req(1, 1'b1, 1'b0, AW'(32'h777), '0);
    for (int c = 0; c < 2 * P + 2 && t1 < 0; c++) begin
      @(negedge clk);
      if (core_taken[1]) begin
        if (t0 < 0) t0 = c;
        else        t1 = c;
      end
    end
    req_valid[1] = 1'b0;
    chk("R10", "repeat service spacing", 64'(t1 - t0), 64'(P));
    repeat (P) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle();
    do_txn(0, 1'b1, AW'(32'h00_1000), 32'h1111_0000);
    do_txn(3, 1'b1, AW'(32'h00_3300), 32'hA0B0_C000);
    do_txn(1, 1'b0, AW'(32'h00_0104), 32'h0000_0100);
    do_txn(2, 1'b0, AW'(32'h00_2208), 32'h0000_0200);
    t_all_order();
    do_txn(3, 1'b0, AW'(32'h00_3ff0), 32'h0000_0300);
    t_back_to_back();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule